// File: doc/BRIEF.md
# Next-Line Streaming Prefetcher

This block sits beside a first-level data cache and watches the demand loads arriving at it. A load that misses on the line directly after the most recently accessed line is taken as part of a sequential stream. The block then proposes a prefetch of the line that follows the missed one. Before that candidate is issued it has to pass six run-time vetoes: memory type, page boundary, pipeline barriers, miss pressure, bus load and store streaming. A candidate that survives is presented on a valid/ready request port.

The request port holds one request at a time. When a new candidate arrives while a request is still waiting, the candidate is thrown away and a saturating drop counter goes up. Lines are 64 bytes and pages are 4 KB. The next-line address keeps the page number and increments only the line index inside the page.

Top module: `nlp_prefetcher`

## Requirements
- R1: While reset is high, and in the first cycle after it, `pf_valid` is 0, `drop_count` is 0 and no line history is held. A second load in sequence straight after reset therefore cannot trigger a request.
- R2: A load with `ld_valid`=1 and `ld_miss`=1 whose line address (`ld_addr[31:6]`) equals the previous load's line address plus one is a stream candidate. It targets the address of the line after the loaded line, with offset bits [5:0] at zero. Accepted candidates appear on `pf_valid`/`pf_addr` one cycle after the load.
- R3: Every valid load, hit or miss, of any memory type, replaces the stored last line. A load that hits, or that is not sequential, creates no candidate.
- R4: Only loads with `ld_memtype` = 2'b11 (write-back) can trigger a request. Codes 2'b00, 2'b01 and 2'b10 never do.
- R5: When the loaded line sits at index 63 of its page (`ld_addr[11:6]` all ones), the candidate is suppressed. The upper address bits of an issued request always equal those of its triggering load.
- R6: No candidate is issued in a cycle with `fence_busy` or `lock_busy` high.
- R7: A candidate is suppressed when `miss_outstanding` is greater than MISS_LIMIT (default 4).
- R8: A candidate is suppressed when `bus_occ` is at least BUS_LIMIT (default 12).
- R9: A store-run counter goes up by one in each cycle with `st_valid`=1 and no valid load. It saturates at its maximum and clears in any cycle with a valid load; in cycles with neither, it keeps its value. Candidates are suppressed while the counter is at least STORE_RUN (default 8).
- R10: Once `pf_valid` is high, it stays high and `pf_addr` stays stable until a cycle with `pf_ready`=1.
- R11: A candidate that passes all vetoes while a request is pending and not accepted in that cycle is discarded. In that case `drop_count` goes up by one, saturating at all ones.
- R12: A candidate arriving in the same cycle that the pending request is accepted replaces it: `pf_valid` stays high with the new address, and no drop is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_valid | input | 1 | Demand load present this cycle |
| ld_addr | input | ADDR_W | Byte address of the load |
| ld_memtype | input | 2 | Memory type code, 2'b11 = write-back |
| ld_miss | input | 1 | Load missed the cache |
| fence_busy | input | 1 | A fence is in progress |
| lock_busy | input | 1 | A locked operation is in progress |
| miss_outstanding | input | MISS_W | Number of outstanding load misses |
| bus_occ | input | BUS_W | Bus occupancy level |
| st_valid | input | 1 | Store present this cycle |
| pf_valid | output | 1 | Prefetch request valid |
| pf_addr | output | ADDR_W | Line-aligned prefetch address |
| pf_ready | input | 1 | Prefetch request accepted |
| drop_count | output | DROP_W | Saturating count of discarded candidates |

## Verification
Every outcome of a load shows up exactly one clock edge later, as a new request on `pf_valid`/`pf_addr` or as a step of `drop_count`. A store cycle affects only loads in later cycles, because the store-run counter is registered. The bench drives inputs just after a rising edge. A behavioural model updates at the same edge the design samples, and the outputs are compared against it after every edge. In this way each stimulus is judged in the cycle its result is due, and neither earlier nor later.

// File: rtl/nlp_pkg.sv
package nlp_pkg;

    localparam int LINE_OFF = 6;
    localparam int PAGE_OFF = 12;
    localparam int IDX_W    = PAGE_OFF - LINE_OFF;

    typedef enum logic [1:0] {
        MT_UC = 2'b00,
        MT_WC = 2'b01,
        MT_WT = 2'b10,
        MT_WB = 2'b11
    } mem_type_e;

    typedef struct packed {
        logic not_wb;
        logic page_end;
        logic barrier;
        logic miss_press;
        logic bus_hot;
        logic store_run;
    } veto_t;

    function automatic logic is_last_in_page(input logic [IDX_W-1:0] idx);
        return &idx;
    endfunction

endpackage

// File: rtl/nlp_store_mon.sv
module nlp_store_mon
    import nlp_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int STORE_RUN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ld_seen,
    input  logic st_seen,
    output logic store_run
);
    localparam logic [CNT_W-1:0] RUN_LIM = CNT_W'(STORE_RUN);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (ld_seen) begin
            run_cnt <= '0;
        end else if (st_seen && run_cnt != CNT_MAX) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign store_run = (run_cnt >= RUN_LIM);

    assert_sat_R9: assert property (@(posedge clk) disable iff (rst)
        (run_cnt == CNT_MAX && st_seen && !ld_seen) |=> run_cnt == CNT_MAX);

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        ld_seen |=> !store_run);

endmodule

// File: rtl/nlp_stream_det.sv
module nlp_stream_det
    import nlp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              ld_miss,
    output logic              hit_stream,
    output logic              page_end,
    output logic [ADDR_W-1:0] next_addr
);
    localparam int LINE_W = ADDR_W - LINE_OFF;

    logic [LINE_W-1:0] last_line;
    logic              last_vld;
    logic [LINE_W-1:0] cur_line;
    logic [IDX_W-1:0]  cur_idx;
    logic [IDX_W-1:0]  nxt_idx;

    assign cur_line = ld_addr[ADDR_W-1:LINE_OFF];
    assign cur_idx  = cur_line[IDX_W-1:0];
    assign nxt_idx  = cur_idx + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_line <= '0;
            last_vld  <= 1'b0;
        end else if (ld_valid) begin
            last_line <= cur_line;
            last_vld  <= 1'b1;
        end
    end

    assign hit_stream = ld_valid && ld_miss && last_vld
                        && (cur_line == last_line + 1'b1);
    assign page_end   = is_last_in_page(cur_idx);
    assign next_addr  = {ld_addr[ADDR_W-1:PAGE_OFF], nxt_idx, {LINE_OFF{1'b0}}};

    assert_hist_R3: assert property (@(posedge clk) disable iff (rst)
        ld_valid |=> last_vld);

endmodule

// File: rtl/nlp_gate.sv
module nlp_gate
    import nlp_pkg::*;
#(
    parameter int MISS_W     = 4,
    parameter int MISS_LIMIT = 4,
    parameter int BUS_W      = 4,
    parameter int BUS_LIMIT  = 12
) (
    input  logic [1:0]        memtype,
    input  logic              page_end,
    input  logic              fence_busy,
    input  logic              lock_busy,
    input  logic [MISS_W-1:0] miss_outstanding,
    input  logic [BUS_W-1:0]  bus_occ,
    input  logic              store_run,
    output veto_t             veto
);
    localparam logic [MISS_W-1:0] MISS_LIM_V = MISS_W'(MISS_LIMIT);
    localparam logic [BUS_W-1:0]  BUS_LIM_V  = BUS_W'(BUS_LIMIT);

    always_comb begin
        veto            = '0;
        veto.not_wb     = (mem_type_e'(memtype) != MT_WB);
        veto.page_end   = page_end;
        veto.barrier    = fence_busy || lock_busy;
        veto.miss_press = (miss_outstanding > MISS_LIM_V);
        veto.bus_hot    = (bus_occ >= BUS_LIM_V);
        veto.store_run  = store_run;
    end

endmodule

// File: rtl/nlp_prefetcher.sv
module nlp_prefetcher
    import nlp_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int MISS_W     = 4,
    parameter int MISS_LIMIT = 4,
    parameter int BUS_W      = 4,
    parameter int BUS_LIMIT  = 12,
    parameter int ST_CNT_W   = 4,
    parameter int STORE_RUN  = 8,
    parameter int DROP_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [1:0]        ld_memtype,
    input  logic              ld_miss,
    input  logic              fence_busy,
    input  logic              lock_busy,
    input  logic [MISS_W-1:0] miss_outstanding,
    input  logic [BUS_W-1:0]  bus_occ,
    input  logic              st_valid,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr,
    input  logic              pf_ready,
    output logic [DROP_W-1:0] drop_count
);
    localparam logic [DROP_W-1:0] DROP_MAX = '1;

    logic              hit_stream;
    logic              page_end;
    logic [ADDR_W-1:0] cand_addr;
    logic              store_run;
    veto_t             veto;
    logic              cand_ok;
    logic              stall;

    nlp_stream_det #(.ADDR_W(ADDR_W)) u_det (
        .clk        (clk),
        .rst        (rst),
        .ld_valid   (ld_valid),
        .ld_addr    (ld_addr),
        .ld_miss    (ld_miss),
        .hit_stream (hit_stream),
        .page_end   (page_end),
        .next_addr  (cand_addr)
    );

    nlp_store_mon #(.CNT_W(ST_CNT_W), .STORE_RUN(STORE_RUN)) u_st (
        .clk       (clk),
        .rst       (rst),
        .ld_seen   (ld_valid),
        .st_seen   (st_valid),
        .store_run (store_run)
    );

    nlp_gate #(
        .MISS_W(MISS_W), .MISS_LIMIT(MISS_LIMIT),
        .BUS_W(BUS_W),   .BUS_LIMIT(BUS_LIMIT)
    ) u_gate (
        .memtype          (ld_memtype),
        .page_end         (page_end),
        .fence_busy       (fence_busy),
        .lock_busy        (lock_busy),
        .miss_outstanding (miss_outstanding),
        .bus_occ          (bus_occ),
        .store_run        (store_run),
        .veto             (veto)
    );

    assign cand_ok = hit_stream && (veto == '0);
    assign stall   = pf_valid && !pf_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            pf_valid   <= 1'b0;
            pf_addr    <= '0;
            drop_count <= '0;
        end else if (cand_ok) begin
            if (stall) begin
                if (drop_count != DROP_MAX) begin
                    drop_count <= drop_count + 1'b1;
                end
            end else begin
                pf_valid <= 1'b1;
                pf_addr  <= cand_addr;
            end
        end else if (pf_valid && pf_ready) begin
            pf_valid <= 1'b0;
        end
    end

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

    assert_drop_R11: assert property (@(posedge clk) disable iff (rst)
        (stall && cand_ok && drop_count != DROP_MAX)
            |=> drop_count == $past(drop_count) + 1'b1);

    assert_wb_only_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pf_valid) |-> $past(ld_valid && ld_memtype == MT_WB));

    assert_in_page_R5: assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> (pf_addr[PAGE_OFF-1:LINE_OFF] != '0
                      && pf_addr[LINE_OFF-1:0] == '0));

    assert_barrier_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(pf_valid) |-> !$past(fence_busy || lock_busy));

endmodule

// File: tb/test_nlp_prefetcher.sv
module test_nlp_prefetcher;
    localparam int PERIOD     = 10;
    localparam int MISS_LIMIT = 4;
    localparam int BUS_LIMIT  = 12;
    localparam int STORE_RUN  = 8;
    localparam int ST_MAX     = 15;
    localparam int DROP_MAX   = 255;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_addr = '0;
    logic [1:0]  ld_memtype = 2'b11;
    logic        ld_miss = 1'b1;
    logic        fence_busy = 1'b0;
    logic        lock_busy = 1'b0;
    logic [3:0]  miss_outstanding = '0;
    logic [3:0]  bus_occ = '0;
    logic        st_valid = 1'b0;
    logic        pf_ready = 1'b1;
    logic        pf_valid;
    logic [31:0] pf_addr;
    logic [7:0]  drop_count;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    always #(PERIOD/2) clk = ~clk;

    nlp_prefetcher i_nlp_prefetcher (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_memtype(ld_memtype), .ld_miss(ld_miss), .fence_busy(fence_busy),
        .lock_busy(lock_busy), .miss_outstanding(miss_outstanding),
        .bus_occ(bus_occ), .st_valid(st_valid), .pf_valid(pf_valid),
        .pf_addr(pf_addr), .pf_ready(pf_ready), .drop_count(drop_count)
    );

    // behavioural reference
    longint m_last = 0;
    bit     m_lv = 0;
    int     m_st = 0;
    bit     m_pv = 0;
    longint m_pa = 0;
    int     m_drops = 0;

    always @(posedge clk) begin
        longint line;
        bit cand;
        if (rst) begin
            m_lv = 0; m_st = 0; m_pv = 0; m_pa = 0; m_drops = 0; m_last = 0;
        end else begin
            line = longint'(ld_addr) / 64;
            cand = ld_valid && ld_miss && m_lv && (line == m_last + 1)
                   && ld_memtype == 2'b11 && (line % 64) != 63
                   && !fence_busy && !lock_busy
                   && int'(miss_outstanding) <= MISS_LIMIT
                   && int'(bus_occ) < BUS_LIMIT && m_st < STORE_RUN;
            if (cand) begin
                if (m_pv && !pf_ready) begin
                    if (m_drops < DROP_MAX) m_drops++;
                end else begin
                    m_pv = 1;
                    m_pa = (line + 1) * 64;
                end
            end else if (m_pv && pf_ready) begin
                m_pv = 0;
            end
            if (ld_valid) m_st = 0;
            else if (st_valid && m_st < ST_MAX) m_st++;
            if (ld_valid) begin
                m_last = line;
                m_lv = 1;
            end
        end
    end

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(pf_valid == m_pv, "pf_valid", longint'(pf_valid), longint'(m_pv));
        if (m_pv) chk(pf_addr == m_pa[31:0], "pf_addr", longint'(pf_addr), m_pa);
        chk(int'(drop_count) == m_drops, "drop_count", longint'(drop_count), longint'(m_drops));
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        compare();
    endtask

    task automatic ld(input logic [31:0] a, input bit miss);
        ld_valid = 1'b1; ld_addr = a; ld_miss = miss;
        cyc();
        ld_valid = 1'b0; ld_miss = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        #(PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state and empty history
        idle(3);
        rst = 1'b0;
        cyc();
        chk(pf_valid == 1'b0, "R1 pf_valid after reset", longint'(pf_valid), 0);
        chk(drop_count == 8'd0, "R1 drop_count after reset", longint'(drop_count), 0);
        ld(32'h0000_1040, 1'b1);
        chk(pf_valid == 1'b0, "R1 no history", longint'(pf_valid), 0);
        idle(1);

        cur_req = "R2";
        ld(32'h0000_2000, 1'b1);
        ld(32'h0000_2040, 1'b1);
        chk(pf_valid && pf_addr == 32'h0000_2080, "R2 next line", longint'(pf_addr), 32'h2080);
        idle(2);

        cur_req = "R3";
        ld(32'h0000_3000, 1'b1);
        ld(32'h0000_3040, 1'b0);
        chk(!pf_valid, "R3 hit ignored", longint'(pf_valid), 0);
        ld(32'h0000_3100, 1'b1);
        chk(!pf_valid, "R3 non sequential", longint'(pf_valid), 0);
        ld_memtype = 2'b00;
        ld(32'h0000_3200, 1'b0);
        ld_memtype = 2'b11;
        ld(32'h0000_3240, 1'b1);
        chk(pf_valid && pf_addr == 32'h3280, "R3 history from any load", longint'(pf_addr), 32'h3280);
        idle(2);

        cur_req = "R4";
        for (int mt = 0; mt < 3; mt++) begin
            ld(32'h0000_4000, 1'b1);
            ld_memtype = 2'(mt);
            ld(32'h0000_4040, 1'b1);
            ld_memtype = 2'b11;
            chk(!pf_valid, "R4 non write-back", longint'(pf_valid), 0);
        end
        idle(1);

        cur_req = "R5";
        ld(32'h0000_5F80, 1'b1);
        ld(32'h0000_5FC0, 1'b1);
        chk(!pf_valid, "R5 page end", longint'(pf_valid), 0);
        ld(32'h0000_6F40, 1'b1);
        ld(32'h0000_6F80, 1'b1);
        chk(pf_valid && pf_addr == 32'h6FC0, "R5 last line allowed", longint'(pf_addr), 32'h6FC0);
        idle(2);

        cur_req = "R6";
        ld(32'h0000_7000, 1'b1);
        fence_busy = 1'b1; ld(32'h0000_7040, 1'b1); fence_busy = 1'b0;
        chk(!pf_valid, "R6 fence", longint'(pf_valid), 0);
        lock_busy = 1'b1; ld(32'h0000_7080, 1'b1); lock_busy = 1'b0;
        chk(!pf_valid, "R6 lock", longint'(pf_valid), 0);
        idle(1);

        cur_req = "R7";
        ld(32'h0000_8000, 1'b1);
        miss_outstanding = 4'd5; ld(32'h0000_8040, 1'b1);
        chk(!pf_valid, "R7 over limit", longint'(pf_valid), 0);
        miss_outstanding = 4'd4; ld(32'h0000_8080, 1'b1);
        chk(pf_valid, "R7 at limit", longint'(pf_valid), 1);
        miss_outstanding = 4'd0;
        idle(2);

        cur_req = "R8";
        ld(32'h0000_9000, 1'b1);
        bus_occ = 4'd12; ld(32'h0000_9040, 1'b1);
        chk(!pf_valid, "R8 bus hot", longint'(pf_valid), 0);
        bus_occ = 4'd11; ld(32'h0000_9080, 1'b1);
        chk(pf_valid, "R8 below limit", longint'(pf_valid), 1);
        bus_occ = 4'd0;
        idle(2);

        cur_req = "R9";
        ld(32'h0000_A000, 1'b1);
        st_valid = 1'b1; idle(7); st_valid = 1'b0;
        ld(32'h0000_A040, 1'b1);
        chk(pf_valid, "R9 seven stores", longint'(pf_valid), 1);
        idle(1);
        st_valid = 1'b1; idle(4); st_valid = 1'b0; idle(2);
        st_valid = 1'b1; idle(4); st_valid = 1'b0;
        ld(32'h0000_A080, 1'b1);
        chk(!pf_valid, "R9 eight stores with gaps", longint'(pf_valid), 0);
        st_valid = 1'b1; idle(20);
        ld(32'h0000_A0C0, 1'b1);
        ld(32'h0000_A100, 1'b1);
        st_valid = 1'b0;
        chk(pf_valid, "R9 load clears run", longint'(pf_valid), 1);
        idle(2);

        cur_req = "R10";
        pf_ready = 1'b0;
        ld(32'h0000_B000, 1'b1);
        ld(32'h0000_B040, 1'b1);
        idle(4);
        chk(pf_valid && pf_addr == 32'hB080, "R10 held", longint'(pf_addr), 32'hB080);

        cur_req = "R11";
        ld(32'h0000_B080, 1'b1);
        chk(drop_count == 8'd1, "R11 dropped", longint'(drop_count), 1);

        cur_req = "R12";
        pf_ready = 1'b1;
        ld(32'h0000_B0C0, 1'b1);
        chk(pf_valid && pf_addr == 32'hB100 && drop_count == 8'd1, "R12 replace",
            longint'(pf_addr), 32'hB100);
        idle(2);

        cur_req = "R11";
        pf_ready = 1'b0;
        for (int i = 0; i < 600; i++) ld(32'h0010_0000 + 32'(i) * 64, 1'b1);
        chk(drop_count == 8'hFF, "R11 saturated", longint'(drop_count), 255);
        pf_ready = 1'b1;
        idle(2);

        cur_req = "R2 R9 R10 R11 R12 mixed";
        begin
            logic [31:0] a;
            a = 32'h0020_0000;
            for (int i = 0; i < 3000; i++) begin
                int r;
                r = int'($urandom_range(0, 99));
                pf_ready = ($urandom_range(0, 2) != 0);
                fence_busy = ($urandom_range(0, 19) == 0);
                lock_busy = ($urandom_range(0, 19) == 0);
                miss_outstanding = 4'($urandom_range(0, 6));
                bus_occ = 4'($urandom_range(0, 13));
                ld_memtype = ($urandom_range(0, 9) == 0) ? 2'b01 : 2'b11;
                st_valid = ($urandom_range(0, 3) == 0);
                if (r < 70) begin
                    a = (r < 5) ? a + 32'h200 : a + 32'h40;
                    ld(a, ($urandom_range(0, 7) != 0));
                end else begin
                    cyc();
                end
            end
        end
        fence_busy = 1'b0; lock_busy = 1'b0; st_valid = 1'b0; pf_ready = 1'b1;
        idle(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule